// File: doc/BRIEF.md
# Iterative Request-Accept Weighted Matcher

This block is the central scheduler of an N-port input-queued cell switch that keeps a separate queue at each input for every output. Once per cell slot it is handed an N×N matrix of per-queue metrics. A zero entry means that the queue is empty. The block then builds an admissible match: no input sends more than one cell and no output receives more than one cell. The result is an N×N transfer matrix, published together with a one-cycle done strobe.

The matcher runs a fixed number of iterations, one clock each. In an iteration, every unmatched input requests every unmatched output for which it holds cells, and each request carries its metric. Each output offers itself to the request with the largest metric. Each input then keeps the offer with the largest metric. Equal metrics are resolved on both sides by round-robin pointers, one pointer per output and one per input. Pairs matched in earlier iterations stay frozen. The metric can be used as a queue length, or reduced by a parameter to a single occupancy bit.

Top module: `iq_rga_matcher`

## Requirements
- R1: At most one bit of `grant` is set in any input row and at most one in any output column. Bit `i*N+j` of `grant` means that input i sends to output j.
- R2: A pair whose metric field is zero is never granted. The field for input i and output j is `metric_in[(i*N+j)*W +: W]`.
- R3: When several unmatched inputs request the same unmatched output, the output offers itself to the request with the strictly largest metric.
- R4: An input that receives several offers accepts the one with the largest metric.
- R5: Let the start edge be the rising clock edge on which `start` is sampled high while the block is idle. `done` is high for exactly one cycle, ITERS cycles after that edge. `grant` takes the new match in that same cycle, and `grant` is cleared to zero on the start edge.
- R6: Equal-metric contention is resolved by a per-output pointer and a per-input pointer. Each pointer is zero after reset. The search starts at the pointer's position and wraps. A pointer moves to one past its winner, and only when that pair is in the final match.
- R7: A pair matched in an iteration stays matched. In later iterations, inputs that are still unmatched compete only for outputs that are still unmatched, so a second iteration can add pairs.
- R8: `grant` holds its value until the next start edge. A `start` that arrives while an iteration is running is ignored, and so is any change of `metric_in` in that time.
- R9: With BINARY=1 every nonzero metric counts as equal, so all contention falls to the round-robin pointers.
- R10: After synchronous reset, `grant` is zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a slot and latches `metric_in` when the block is idle |
| metric_in | input | N*N*W | Per-queue metrics, field `(i*N+j)*W` for input i to output j |
| grant | output | N*N | Registered transfer matrix, bit `i*N+j` |
| done | output | 1 | One-cycle strobe marking a new `grant` |

## Verification
A wrong round-robin pointer stays hidden until a slot with equal metrics contends for the same port. It then shows as the wrong winner in `grant` at that slot's done strobe, so the bench repeats equal-metric slots and follows the rotation slot by slot. A corrupted match register or iteration count shows up within the same slot, either as a row or column with two grants or as a done strobe at the wrong distance from the start edge. A reference model compares `grant` and `done` on every clock, and a second instance runs in occupancy mode, so errors in the pointers or the iteration count show up as soon as they change an output.

// File: rtl/rga_pkg.sv
package rga_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} phase_t;

  // next position after idx in a ring of n
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rga_wt_arb.sv
// Weighted pick: largest metric among requests, ties broken from ptr onward.
module rga_wt_arb #(
  parameter int N  = 4,
  parameter int W  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] wt,
  input  logic [PW-1:0]  ptr,
  output logic [N-1:0]   pick
);
  logic [W-1:0] top_w;
  logic [N-1:0] cand;
  logic         hit;
  int unsigned  idx;

  always_comb begin
    top_w = '0;
    for (int k = 0; k < N; k++)
      if (req[k] && (wt[k*W +: W] > top_w)) top_w = wt[k*W +: W];
    for (int k = 0; k < N; k++)
      cand[k] = req[k] && (wt[k*W +: W] == top_w);
    pick = '0;
    hit  = 1'b0;
    idx  = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!hit && cand[idx]) begin
        pick[idx] = 1'b1;
        hit       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_rga_matcher.sv
module iq_rga_matcher #(
  parameter int N      = 4,
  parameter int W      = 4,
  parameter int ITERS  = $clog2(N),
  parameter bit BINARY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N*N*W-1:0] metric_in,
  output logic [N*N-1:0]   grant,
  output logic             done
);
  import rga_pkg::*;

  localparam int NN = N * N;
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(ITERS + 1);

  phase_t           phase;
  logic [CW-1:0]    iter_q;
  logic [NN*W-1:0]  lat_q;
  logic [NN*W-1:0]  eff;
  logic [NN-1:0]    match_q, match_nxt;
  logic [PW-1:0]    optr_q [N];
  logic [PW-1:0]    iptr_q [N];
  logic [PW-1:0]    optr_n [N];
  logic [PW-1:0]    iptr_n [N];
  logic [N-1:0]     row_busy, col_busy;
  logic [N-1:0]     oreq [N];
  logic [N*W-1:0]   owt  [N];
  logic [N-1:0]     ogr  [N];
  logic [N-1:0]     ireq [N];
  logic [N*W-1:0]   iwt  [N];
  logic [N-1:0]     iacc [N];
  logic             last_iter;
  logic             run_w;

  // metric conditioning: length or occupancy bit
  for (genvar k = 0; k < NN; k++) begin : g_eff
    if (BINARY && W > 1) begin : g_bin
      assign eff[k*W +: W] = {{(W-1){1'b0}}, |metric_in[k*W +: W]};
    end else begin : g_len
      assign eff[k*W +: W] = metric_in[k*W +: W];
    end
  end

  always_comb begin
    row_busy = '0;
    col_busy = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (match_q[i*N+j]) begin
          row_busy[i] = 1'b1;
          col_busy[j] = 1'b1;
        end
  end

  // request / offer / accept network
  for (genvar j = 0; j < N; j++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_in
      assign oreq[j][i]         = (lat_q[(i*N+j)*W +: W] != '0) && !row_busy[i] && !col_busy[j];
      assign owt[j][i*W +: W]   = lat_q[(i*N+j)*W +: W];
      assign ireq[i][j]         = ogr[j][i];
      assign iwt[i][j*W +: W]   = lat_q[(i*N+j)*W +: W];
      assign match_nxt[i*N+j]   = match_q[i*N+j] | iacc[i][j];
    end
    rga_wt_arb #(.N(N), .W(W), .PW(PW)) u_oarb (
      .req(oreq[j]), .wt(owt[j]), .ptr(optr_q[j]), .pick(ogr[j]));
  end

  for (genvar i = 0; i < N; i++) begin : g_acc
    rga_wt_arb #(.N(N), .W(W), .PW(PW)) u_iarb (
      .req(ireq[i]), .wt(iwt[i]), .ptr(iptr_q[i]), .pick(iacc[i]));
  end

  // pointer successors from the final match
  always_comb begin
    for (int j = 0; j < N; j++) begin
      optr_n[j] = optr_q[j];
      for (int i = 0; i < N; i++)
        if (match_nxt[i*N+j]) optr_n[j] = PW'(wrap_next(i, N));
    end
    for (int i = 0; i < N; i++) begin
      iptr_n[i] = iptr_q[i];
      for (int j = 0; j < N; j++)
        if (match_nxt[i*N+j]) iptr_n[i] = PW'(wrap_next(j, N));
    end
  end

  assign run_w     = (phase == S_RUN);
  assign last_iter = run_w && (iter_q == CW'(ITERS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= S_IDLE;
      iter_q  <= '0;
      lat_q   <= '0;
      match_q <= '0;
      grant   <= '0;
      done    <= 1'b0;
      for (int k = 0; k < N; k++) begin
        optr_q[k] <= '0;
        iptr_q[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (phase)
        S_IDLE: if (start) begin
          lat_q   <= eff;
          match_q <= '0;
          grant   <= '0;
          iter_q  <= '0;
          phase   <= S_RUN;
        end
        S_RUN: begin
          match_q <= match_nxt;
          iter_q  <= iter_q + 1'b1;
          if (last_iter) begin
            phase <= S_IDLE;
            grant <= match_nxt;
            done  <= 1'b1;
            for (int k = 0; k < N; k++) begin
              optr_q[k] <= optr_n[k];
              iptr_q[k] <= iptr_n[k];
            end
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_rga_matcher_chk.sv
module iq_rga_matcher_chk #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int ITERS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [N*N-1:0]   grant,
  input logic [N*N*W-1:0] lat
);
  logic [N*N-1:0] nz;
  logic [N-1:0]   colv [N];
  int             since;

  always_comb begin
    for (int k = 0; k < N*N; k++) nz[k] = |lat[k*W +: W];
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) colv[c][r] = grant[r*N+c];
  end

  // cycles since the last accepted start
  always_ff @(posedge clk) begin
    if (rst)                since <= 0;
    else if (start && !busy) since <= 0;
    else if (busy)          since <= since + 1;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    a_r1_row_single: assert property (@(posedge clk) disable iff (rst) $onehot0(grant[r*N +: N]));
    a_r1_col_single: assert property (@(posedge clk) disable iff (rst) $onehot0(colv[r]));
  end

  a_r2_no_empty_pair: assert property (@(posedge clk) disable iff (rst)
    done |-> ((grant & ~nz) == '0));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r5_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == ITERS && !busy));
  a_r8_grant_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && grant != '0) |-> $stable(grant));
endmodule

bind iq_rga_matcher iq_rga_matcher_chk #(.N(N), .W(W), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(run_w),
  .done(done), .grant(grant), .lat(lat_q));

// File: tb/tb_iq_rga_matcher.sv
module rga_ref_model #(
  parameter int N = 4, parameter int W = 4, parameter int ITERS = 2, parameter int BIN = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N*N*W-1:0] metric,
  output logic [N*N-1:0]   exp_grant,
  output logic             exp_done
);
  int wt [N][N];
  bit mt [N][N];
  int optr [N];
  int iptr [N];
  int offer [N];
  int pick [N];
  bit running;
  int step, best, ii, jj;

  function automatic bit row_taken(int r);
    for (int c = 0; c < N; c++) if (mt[r][c]) return 1;
    return 0;
  endfunction
  function automatic bit col_taken(int c);
    for (int r = 0; r < N; r++) if (mt[r][c]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      running = 0; step = 0;
      for (int a = 0; a < N; a++) begin
        optr[a] = 0; iptr[a] = 0;
        for (int b = 0; b < N; b++) mt[a][b] = 0;
      end
      exp_grant <= '0; exp_done <= 1'b0;
    end else begin
      exp_done <= 1'b0;
      if (running) begin
        for (int j = 0; j < N; j++) begin
          offer[j] = -1; best = 0;
          if (!col_taken(j))
            for (int k = 0; k < N; k++) begin
              ii = (optr[j] + k) % N;
              if (!row_taken(ii) && wt[ii][j] > best) begin best = wt[ii][j]; offer[j] = ii; end
            end
        end
        for (int i = 0; i < N; i++) begin
          pick[i] = -1; best = 0;
          for (int k = 0; k < N; k++) begin
            jj = (iptr[i] + k) % N;
            if (offer[jj] == i && wt[i][jj] > best) begin best = wt[i][jj]; pick[i] = jj; end
          end
        end
        for (int i = 0; i < N; i++) if (pick[i] >= 0) mt[i][pick[i]] = 1;
        step++;
        if (step == ITERS) begin
          running = 0;
          for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
              if (mt[i][j]) begin
                optr[j] = (i + 1) % N;
                iptr[i] = (j + 1) % N;
                exp_grant[i*N+j] <= 1'b1;
              end
          exp_done <= 1'b1;
        end
      end else if (start) begin
        running = 1; step = 0;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            wt[i][j] = int'(metric[(i*N+j)*W +: W]);
            if (BIN != 0 && wt[i][j] != 0) wt[i][j] = 1;
            mt[i][j] = 0;
          end
        exp_grant <= '0;
      end
    end
  end
endmodule

module tb_iq_rga_matcher;
  localparam int N = 4, W = 4, IT = 2;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [N*N*W-1:0] metric = '0;
  logic [N*N-1:0] g_len, g_occ, e_len, e_occ;
  logic d_len, d_occ, ed_len, ed_occ;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  iq_rga_matcher #(.N(N), .W(W), .ITERS(IT), .BINARY(1'b0)) dut (
    .clk(clk), .rst(rst), .start(start), .metric_in(metric), .grant(g_len), .done(d_len));
  iq_rga_matcher #(.N(N), .W(W), .ITERS(IT), .BINARY(1'b1)) dut_occ (
    .clk(clk), .rst(rst), .start(start), .metric_in(metric), .grant(g_occ), .done(d_occ));
  rga_ref_model #(.N(N), .W(W), .ITERS(IT), .BIN(0)) ref_len (
    .clk(clk), .rst(rst), .start(start), .metric(metric), .exp_grant(e_len), .exp_done(ed_len));
  rga_ref_model #(.N(N), .W(W), .ITERS(IT), .BIN(1)) ref_occ (
    .clk(clk), .rst(rst), .start(start), .metric(metric), .exp_grant(e_occ), .exp_done(ed_occ));

  // cycle-by-cycle comparison against the models
  always @(negedge clk) if (!rst) begin
    n_chk++;
    if (g_len !== e_len || d_len !== ed_len) begin
      n_fail++;
      $display("FAIL %s len-mode cycle: grant=%h done=%b expected grant=%h done=%b",
               cur_req, g_len, d_len, e_len, ed_len);
    end
    n_chk++;
    if (g_occ !== e_occ || d_occ !== ed_occ) begin
      n_fail++;
      $display("FAIL %s occ-mode (R9) cycle: grant=%h done=%b expected grant=%h done=%b",
               cur_req, g_occ, d_occ, e_occ, ed_occ);
    end
  end

  task automatic check(input string req, input logic [N*N-1:0] got, input logic [N*N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic set_m(input int i, input int j, input int v);
    metric[(i*N+j)*W +: W] = W'(v);
  endtask

  // start at a negedge, return at the negedge where done is visible
  task automatic run_slot();
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (IT) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R5 watchdog expired: actual=no completion expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N*N-1:0] nzm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 grant after reset", g_len, '0);
    check("R10 done after reset", {15'd0, d_len}, '0);

    // R3: largest request wins the output; R9 occupancy tie goes to pointer 0
    cur_req = "R3";
    metric = '0; set_m(0, 1, 3); set_m(2, 1, 9);
    @(negedge clk); run_slot();
    check("R3 largest metric wins output", g_len, 16'h0200);
    check("R5 done strobe", {15'd0, d_len}, 16'd1);
    check("R9 occupancy tie to rr pointer", g_occ, 16'h0002);
    @(negedge clk);
    check("R5 done is one cycle", {15'd0, d_len}, '0);

    // R4: input keeps largest offer
    cur_req = "R4";
    metric = '0; set_m(0, 1, 5); set_m(0, 2, 7);
    run_slot();
    check("R4 input keeps largest offer", g_len, 16'h0004);

    // R6: equal metrics rotate through output 0 pointer
    cur_req = "R6";
    metric = '0;
    for (int i = 0; i < N; i++) set_m(i, 0, 4);
    for (int s = 0; s < 5; s++) begin
      run_slot();
      check("R6 round-robin winner", g_len, 16'(1) << (((s % N) * N)));
    end

    // R7: second iteration adds a pair, first pair stays
    cur_req = "R7";
    metric = '0; set_m(0, 0, 5); set_m(0, 1, 2); set_m(1, 0, 3); set_m(1, 1, 1);
    run_slot();
    check("R7 frozen pair plus second-iteration pair", g_len, 16'h0021);

    // R8: hold while idle
    cur_req = "R8";
    repeat (3) @(negedge clk);
    check("R8 grant held while idle", g_len, 16'h0021);

    // R8: start and metric changes while busy are ignored; R5 clear on start
    metric = '0; set_m(0, 1, 3); set_m(2, 1, 9);
    start = 1'b1;
    @(negedge clk);
    check("R5 grant cleared at start", g_len, '0);
    metric = '1;
    repeat (IT - 1) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8 busy start ignored", g_len, 16'h0200);
    @(negedge clk);

    // R1/R2: random slots
    cur_req = "R1 R2";
    for (int s = 0; s < 60; s++) begin
      for (int k = 0; k < N*N; k++)
        metric[k*W +: W] = ($urandom_range(0, 1) == 0) ? '0 : W'($urandom_range(1, 15));
      for (int k = 0; k < N*N; k++) nzm[k] = |metric[k*W +: W];
      run_slot();
      check("R2 no grant on empty queue", g_len & ~nzm, '0);
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule